// File: doc/BRIEF.md
# Scaled-Index Offset Address Generator

This unit forms a memory operand offset from as many as three optional terms. The first is a base register. The second is an index register shifted left by a two-bit scale code. The third is a sign-extended displacement carried by the instruction. It names the base and index registers on two register-number outputs. The surrounding register file answers with both 32-bit values in the same cycle.

A single start strobe samples the whole request. One clock edge later the unit presents the offset together with a one-cycle valid pulse. A mode input selects the offset width. In 16-bit mode the sum is cut to its low half and the upper half reads zero. In 32-bit mode the sum wraps around 2^32.

Register 4 is the stack pointer and may not serve as index. A request that names it as index returns an illegal-encoding pulse instead of a valid result. Segment translation, paging and operand fetch belong to later stages.

Top module: `ea_gen`

## Requirements
- R1: The offset equals base term plus scaled index term plus displacement term. Each term has its own enable (`base_en_i`, `index_en_i`, `disp_en_i`), and a disabled term contributes zero.
- R2: Any of registers 0 to 7, register 4 included, may serve as base. `rf_base_num_o` carries `base_sel_i` and `rf_index_num_o` carries `index_sel_i`, combinationally, so the returned data belongs to the request being sampled.
- R3: A request with `index_en_i`=1 and `index_sel_i`=4 produces `illegal_o`=1 and `valid_o`=0 on the next edge, and `offset_o` reads zero. With the index disabled, register 4 in `index_sel_i` is not illegal.
- R4: Scale code `scale_i` 2'b00, 2'b01, 2'b10 and 2'b11 multiply the index by 1, 2, 4 and 8. Bits shifted past bit 31 are lost.
- R5: `disp_i` is a 32-bit two's-complement value, so a negative displacement subtracts from the other terms.
- R6: With `prot_mode_i`=0, `offset_o[15:0]` holds the low 16 bits of the sum and `offset_o[31:16]` is zero.
- R7: With `prot_mode_i`=1, `offset_o` is the 32-bit sum modulo 2^32 and no overflow is reported.
- R8: Inputs are sampled on the rising edge where `start_i`=1, and the result appears after that edge. `valid_o` or `illegal_o` is high for exactly one cycle per start, and a start on consecutive cycles yields consecutive results. With `start_i`=0 both strobes are low and `offset_o` keeps its last value.
- R9: While `rst_ni` is low, `offset_o` is zero and `valid_o` and `illegal_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request strobe; samples all request inputs |
| prot_mode_i | input | 1 | 1: 32-bit offset, 0: 16-bit offset |
| base_en_i | input | 1 | Base term present |
| base_sel_i | input | 3 | Base register number |
| index_en_i | input | 1 | Index term present |
| index_sel_i | input | 3 | Index register number (4 is illegal) |
| scale_i | input | 2 | Index scale code (shift amount 0..3) |
| disp_en_i | input | 1 | Displacement term present |
| disp_i | input | 32 | Sign-extended displacement |
| rf_base_num_o | output | 3 | Register-file read number for base |
| rf_index_num_o | output | 3 | Register-file read number for index |
| rf_base_data_i | input | 32 | Register-file data for base |
| rf_index_data_i | input | 32 | Register-file data for index |
| offset_o | output | 32 | Registered offset |
| valid_o | output | 1 | One-cycle result strobe |
| illegal_o | output | 1 | One-cycle illegal-encoding strobe |

## Verification
Two situations are hard to reach from the ports. The first is a 16-bit-mode request whose sum carries out of bit 15, or goes negative through the displacement, while the upper register bits are non-zero. The second is an illegal request placed between two legal requests in a back-to-back burst. The bench fills the modelled register file with values that have high bits set. It then issues directed requests that straddle the 16-bit boundary, with negative displacements and with scale 8 on large indices. It also runs bursts of starts on consecutive cycles in which a stack-pointer index request is interleaved. Randomised requests, drawn across all enable and scale combinations and both modes, fill in the rest.

// File: rtl/ea_pkg.sv
package ea_pkg;

  localparam int unsigned EA_SCALE_W = 2;

  typedef enum logic [EA_SCALE_W-1:0] {
    SC_X1 = 2'b00,
    SC_X2 = 2'b01,
    SC_X4 = 2'b10,
    SC_X8 = 2'b11
  } scale_e;

endpackage

// File: rtl/ea_operand_sel.sv
module ea_operand_sel #(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned RN_W   = 3,
  parameter int unsigned SP_IDX = 4
) (
  input  logic            base_en_i,
  input  logic [RN_W-1:0] base_sel_i,
  input  logic            index_en_i,
  input  logic [RN_W-1:0] index_sel_i,
  output logic [RN_W-1:0] rf_base_num_o,
  output logic [RN_W-1:0] rf_index_num_o,
  input  logic [XLEN-1:0] rf_base_data_i,
  input  logic [XLEN-1:0] rf_index_data_i,
  output logic [XLEN-1:0] base_term_o,
  output logic [XLEN-1:0] index_raw_o,
  output logic            illegal_o
);

  localparam logic [RN_W-1:0] SP_NUM = RN_W'(SP_IDX);

  assign rf_base_num_o  = base_sel_i;
  assign rf_index_num_o = index_sel_i;

  assign illegal_o   = index_en_i && (index_sel_i == SP_NUM);
  assign base_term_o = base_en_i ? rf_base_data_i : '0;
  assign index_raw_o = (index_en_i && !illegal_o) ? rf_index_data_i : '0;

endmodule

// File: rtl/ea_index_scaler.sv
module ea_index_scaler
  import ea_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter bit          USE_MUX = 1'b0
) (
  input  logic [XLEN-1:0]       index_i,
  input  logic [EA_SCALE_W-1:0] scale_i,
  output logic [XLEN-1:0]       scaled_o
);

  generate
    if (USE_MUX) begin : g_mux
      always_comb begin
        unique case (scale_e'(scale_i))
          SC_X1:   scaled_o = index_i;
          SC_X2:   scaled_o = {index_i[XLEN-2:0], 1'b0};
          SC_X4:   scaled_o = {index_i[XLEN-3:0], 2'b0};
          SC_X8:   scaled_o = {index_i[XLEN-4:0], 3'b0};
          default: scaled_o = index_i;
        endcase
      end
    end else begin : g_shift
      assign scaled_o = index_i << scale_i;
    end
  endgenerate

endmodule

// File: rtl/ea_sum_fold.sv
module ea_sum_fold #(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned REAL_W = 16
) (
  input  logic [XLEN-1:0] base_i,
  input  logic [XLEN-1:0] index_i,
  input  logic [XLEN-1:0] disp_i,
  input  logic            prot_mode_i,
  output logic [XLEN-1:0] offset_o
);

  localparam logic [XLEN-1:0] REAL_MASK = {{(XLEN-REAL_W){1'b0}}, {REAL_W{1'b1}}};

  logic [XLEN-1:0] full_sum;

  // wraps modulo 2^XLEN by width
  assign full_sum = base_i + index_i + disp_i;
  assign offset_o = prot_mode_i ? full_sum : (full_sum & REAL_MASK);

endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_pkg::*;
#(
  parameter int unsigned XLEN           = 32,
  parameter int unsigned REAL_W         = 16,
  parameter int unsigned NREG           = 8,
  parameter int unsigned SP_IDX         = 4,
  parameter bit          USE_MUX_SCALER = 1'b0
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic                      prot_mode_i,
  input  logic                      base_en_i,
  input  logic [$clog2(NREG)-1:0]   base_sel_i,
  input  logic                      index_en_i,
  input  logic [$clog2(NREG)-1:0]   index_sel_i,
  input  logic [EA_SCALE_W-1:0]     scale_i,
  input  logic                      disp_en_i,
  input  logic [XLEN-1:0]           disp_i,
  output logic [$clog2(NREG)-1:0]   rf_base_num_o,
  output logic [$clog2(NREG)-1:0]   rf_index_num_o,
  input  logic [XLEN-1:0]           rf_base_data_i,
  input  logic [XLEN-1:0]           rf_index_data_i,
  output logic [XLEN-1:0]           offset_o,
  output logic                      valid_o,
  output logic                      illegal_o
);

  localparam int unsigned RN_W = $clog2(NREG);

  logic [XLEN-1:0] base_term, index_raw, index_scaled, disp_term, sum_d;
  logic            illegal_d;
  logic [XLEN-1:0] offset_q;
  logic            valid_q, illegal_q;

  ea_operand_sel #(
    .XLEN   (XLEN),
    .RN_W   (RN_W),
    .SP_IDX (SP_IDX)
  ) u_sel (
    .base_en_i       (base_en_i),
    .base_sel_i      (base_sel_i),
    .index_en_i      (index_en_i),
    .index_sel_i     (index_sel_i),
    .rf_base_num_o   (rf_base_num_o),
    .rf_index_num_o  (rf_index_num_o),
    .rf_base_data_i  (rf_base_data_i),
    .rf_index_data_i (rf_index_data_i),
    .base_term_o     (base_term),
    .index_raw_o     (index_raw),
    .illegal_o       (illegal_d)
  );

  ea_index_scaler #(
    .XLEN    (XLEN),
    .USE_MUX (USE_MUX_SCALER)
  ) u_scale (
    .index_i  (index_raw),
    .scale_i  (scale_i),
    .scaled_o (index_scaled)
  );

  assign disp_term = disp_en_i ? disp_i : '0;

  ea_sum_fold #(
    .XLEN   (XLEN),
    .REAL_W (REAL_W)
  ) u_sum (
    .base_i      (base_term),
    .index_i     (index_scaled),
    .disp_i      (disp_term),
    .prot_mode_i (prot_mode_i),
    .offset_o    (sum_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      offset_q  <= '0;
      valid_q   <= 1'b0;
      illegal_q <= 1'b0;
    end else if (start_i) begin
      offset_q  <= illegal_d ? '0 : sum_d;
      valid_q   <= !illegal_d;
      illegal_q <= illegal_d;
    end else begin
      valid_q   <= 1'b0;
      illegal_q <= 1'b0;
    end
  end

  assign offset_o  = offset_q;
  assign valid_o   = valid_q;
  assign illegal_o = illegal_q;

  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && illegal_o)); // R3

  AST_SP_INDEX_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && index_en_i && index_sel_i == RN_W'(SP_IDX)) |=> (illegal_o && offset_o == '0)); // R3

  AST_REAL_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !prot_mode_i) |=> (offset_o[XLEN-1:REAL_W] == '0)); // R6

  AST_NO_START_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> (!valid_o && !illegal_o && $stable(offset_o))); // R8

  AST_START_ANSWERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> $countones({valid_o, illegal_o}) == 1); // R8

  AST_RF_NUMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_base_num_o == base_sel_i && rf_index_num_o == index_sel_i); // R2

endmodule

// File: tb/tb_ea_gen.sv
module tb_ea_gen;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, prot_mode_i = 1'b0;
  logic        base_en_i = 1'b0, index_en_i = 1'b0, disp_en_i = 1'b0;
  logic [2:0]  base_sel_i = '0, index_sel_i = '0;
  logic [1:0]  scale_i = '0;
  logic [31:0] disp_i = '0;
  logic [2:0]  rf_base_num_o, rf_index_num_o;
  logic [31:0] rf_base_data_i, rf_index_data_i;
  logic [31:0] offset_o;
  logic        valid_o, illegal_o;

  logic [31:0] regs [8];

  always #2.5 clk_i = ~clk_i;

  assign rf_base_data_i  = regs[rf_base_num_o];
  assign rf_index_data_i = regs[rf_index_num_o];

  ea_gen dut (.*);

  typedef struct {
    logic [31:0] off;
    bit          ill;
    string       req;
  } exp_t;

  exp_t        sb[$];
  int          n_vec = 0, n_bad = 0;
  logic [31:0] last_off = '0;

  function automatic logic [31:0] ref_off(bit pm, bit be, logic [31:0] b, bit ie,
                                          logic [31:0] x, logic [1:0] sc, bit de,
                                          logic [31:0] d);
    logic [31:0] s, xs;
    case (sc)
      2'd0: xs = x;
      2'd1: xs = x * 2;
      2'd2: xs = x * 4;
      default: xs = x * 8;
    endcase
    s = (be ? b : 32'd0) + (ie ? xs : 32'd0) + (de ? d : 32'd0);
    return pm ? s : {16'd0, s[15:0]};
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // call at negedge; leaves start high for the coming edge
  task automatic issue(bit pm, bit be, logic [2:0] bs, bit ie, logic [2:0] is,
                       logic [1:0] sc, bit de, logic [31:0] d, string req);
    exp_t e;
    start_i = 1'b1; prot_mode_i = pm;
    base_en_i = be; base_sel_i = bs;
    index_en_i = ie; index_sel_i = is; scale_i = sc;
    disp_en_i = de; disp_i = d;
    e.ill = ie && (is == 3'd4);
    e.off = e.ill ? 32'd0 : ref_off(pm, be, regs[bs], ie, regs[is], sc, de, d);
    e.req = req;
    sb.push_back(e);
    @(negedge clk_i);
  endtask

  task automatic idle(int n);
    start_i = 1'b0;
    disp_i  = $urandom; base_sel_i = 3'($urandom); index_sel_i = 3'($urandom);
    repeat (n) @(negedge clk_i);
  endtask

  // monitor: compare just after every edge
  always @(posedge clk_i) begin
    #1;
    if (rst_ni) begin
      if (valid_o || illegal_o) begin
        if (sb.size() == 0) begin
          check(1'b0, "R8 unexpected strobe", {30'd0, valid_o, illegal_o}, 32'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(illegal_o == e.ill && valid_o == !e.ill, {e.req, " strobe"},
                {30'd0, valid_o, illegal_o}, {30'd0, !e.ill, e.ill});
          check(offset_o == e.off, {e.req, " offset"}, offset_o, e.off);
          last_off = e.off;
        end
      end else if (sb.size() != 0) begin
        exp_t e;
        e = sb.pop_front();
        check(1'b0, {e.req, " R8 missing result"}, offset_o, e.off);
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    n_bad++; n_vec++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    regs[0] = 32'h0000_0000; regs[1] = 32'h1234_8FF0; regs[2] = 32'hFFFF_FFF8;
    regs[3] = 32'h8000_0001; regs[4] = 32'h0BAD_5EED; regs[5] = 32'h0000_7FFF;
    regs[6] = 32'hA5A5_0010; regs[7] = 32'h2000_0003;
    repeat (3) @(negedge clk_i);
    check(offset_o == 0 && !valid_o && !illegal_o, "R9 reset", offset_o, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 each term alone and combined
    issue(1, 1, 3'd1, 0, 3'd0, 2'd0, 0, 32'd0, "R1 base only");
    issue(1, 0, 3'd0, 1, 3'd6, 2'd0, 0, 32'd0, "R1 index only");
    issue(1, 0, 3'd0, 0, 3'd0, 2'd0, 1, 32'h0000_1000, "R1 disp only");
    issue(1, 0, 3'd3, 0, 3'd4, 2'd3, 0, 32'h55, "R1 none present");
    issue(1, 1, 3'd7, 1, 3'd5, 2'd1, 1, 32'h10, "R1 all three");
    idle(2);
    // R2 stack pointer as base is fine
    issue(1, 1, 3'd4, 1, 3'd1, 2'd0, 0, 32'd0, "R2 reg4 base");
    // R4 all scales on a large index
    for (int s = 0; s < 4; s++) issue(1, 0, 3'd0, 1, 3'd3, 2'(s), 0, 32'd0, "R4 scale");
    issue(1, 1, 3'd6, 1, 3'd2, 2'd3, 0, 32'd0, "R4 scale x8 neg");
    idle(1);
    // R5 negative displacement
    issue(1, 1, 3'd7, 0, 3'd0, 2'd0, 1, 32'hFFFF_FFF0, "R5 neg disp");
    issue(1, 0, 3'd0, 0, 3'd0, 2'd0, 1, 32'hFFFF_8000, "R5 neg disp only");
    // R6 real mode wrap
    issue(0, 1, 3'd1, 1, 3'd5, 2'd0, 0, 32'd0, "R6 carry out of bit15");
    issue(0, 1, 3'd6, 0, 3'd0, 2'd0, 1, 32'hFFFF_FFE0, "R6 negative wrap");
    issue(0, 1, 3'd2, 1, 3'd3, 2'd3, 1, 32'h7, "R6 mixed");
    // R7 protected wrap
    issue(1, 1, 3'd3, 1, 3'd3, 2'd0, 1, 32'hFFFF_FFFF, "R7 wrap 2^32");
    idle(1);
    // R3 illegal in a burst, and disabled index with reg4
    issue(1, 1, 3'd1, 1, 3'd2, 2'd1, 0, 32'd0, "R8 burst a");
    issue(1, 1, 3'd1, 1, 3'd4, 2'd2, 1, 32'h44, "R3 sp index");
    issue(0, 1, 3'd5, 1, 3'd4, 2'd0, 0, 32'd0, "R3 sp index real");
    issue(1, 1, 3'd5, 0, 3'd4, 2'd3, 1, 32'h1, "R3 sp index disabled");
    idle(1);
    // R8 hold while idle
    issue(1, 1, 3'd7, 1, 3'd1, 2'd2, 1, 32'h100, "R8 before hold");
    idle(4);
    check(!valid_o && !illegal_o && offset_o == last_off, "R8 hold", offset_o, last_off);

    // random
    for (int i = 0; i < 300; i++) begin
      regs[$urandom_range(7)] = $urandom;
      issue(bit'($urandom), bit'($urandom), 3'($urandom), bit'($urandom), 3'($urandom),
            2'($urandom), bit'($urandom), $urandom, "R1 random");
      if ($urandom_range(3) == 0) idle(1);
    end
    idle(3);

    // R9 reset after activity
    issue(1, 1, 3'd1, 0, 3'd0, 2'd0, 0, 32'd0, "R9 pre-reset");
    idle(1);
    rst_ni = 1'b0;
    #1;
    check(offset_o == 0 && !valid_o && !illegal_o, "R9 async reset", offset_o, 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    idle(2);
    check(sb.size() == 0, "R8 scoreboard drained", 32'(sb.size()), 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule